// File: doc/BRIEF.md
# Parallel-Port Bitstream Loader

This block loads a configuration image into a target FPGA through an 8-bit parallel configuration port. A reset command starts the sequence. The block pulls the target's program line low with chip-select and the configuration clock held high. It then releases program and waits for the target's init line. Image bytes arrive on a valid/ready byte stream. Each byte is placed on the data bus and clocked in with one configuration clock pulse. While loading, the block keeps a modulo-256 checksum and a byte count.

A packet whose last-byte flag arrives before the 64th byte marks the end of the image. The block then runs a closing sequence:
- 64 clock pulses with chip-select low;
- chip-select raised, then 4 more pulses;
- all configuration pins released.

A progress code built from the init line at three points records how the load went.

A status query releases the shared program/done line and samples it. The block then returns a 9-byte status record. If the target reports unconfigured, the query also restarts the reset phase.

Top module: `cfgm_master`

## Requirements
- R1: In the reset phase the block drives program (`prog_o`) low and chip-select and the configuration clock high. It drives read/write low and places the mode value captured with the reset command on `mode_o`. It holds this for `RST_CYC` cycles with `s_ready_o` low.
- R2: After the reset phase, program goes high and chip-select and the clock go low. The init line is polled for up to `POLL_MAX` cycles. The progress code becomes 200 if init is high when polling ends, else 100.
- R3: Entering the reset phase clears the checksum and the byte count to zero.
- R4: Each accepted byte is stable on `data_o` before and during one configuration clock pulse. The pulse is `HALF` cycles high then `HALF` cycles low. `s_ready_o` stays low from acceptance until the pulse ends.
- R5: The checksum is the modulo-256 sum of the loaded bytes. The byte count is the number of loaded bytes.
- R6: A packet ending with `s_last_i` after fewer than 64 bytes starts the closing sequence. A 64-byte packet does not start it, and loading continues.
- R7: The closing sequence adds 20 to the code if init is high, else 10. It then gives 64 clock pulses with chip-select low, raises chip-select, and gives 4 more pulses.
- R8: After the closing pulses, `bus_oe_o` and `prog_oe_o` drop for one cycle. The code gains 2 if init is high, else 1, so a clean load ends at 222. Program is then driven high again.
- R9: A query releases the program line (`prog_oe_o` low) and samples `done_i`. If it is high, the record reports configured and program is driven high again. If it is low, the record reports unconfigured and the reset phase restarts.
- R10: The record on `stat_o` holds byte k in bits 8k+7..8k:
  - byte 0: 0 for configured, 1 for unconfigured;
  - byte 1: checksum;
  - bytes 2..5: byte count, least significant first;
  - byte 6: progress code;
  - byte 7: `ext_res_i`;
  - byte 8: the constant 1.
- R11: `reset_cmd_i` restarts the reset phase from any state, discarding a byte in progress.
- R12: After `rst_n`, all configuration outputs are released and `s_ready_o` and `stat_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_cmd_i | input | 1 | Start or restart the reset phase |
| mode_i | input | MODE_W | Mode value captured with the reset command |
| stat_req_i | input | 1 | Status query request |
| ext_res_i | input | 8 | External load result placed in record byte 7 |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Last byte of a packet |
| s_ready_o | output | 1 | Stream ready |
| prog_o | output | 1 | Value driven on the shared program/done line |
| prog_oe_o | output | 1 | Drive enable of the program/done line |
| done_i | input | 1 | Sampled level of the program/done line |
| init_i | input | 1 | Target init line |
| bus_oe_o | output | 1 | Drive enable of mode, chip-select, read/write, clock and data |
| mode_o | output | MODE_W | Mode pins |
| cs_o | output | 1 | Chip-select |
| rdwr_o | output | 1 | Read/write select (low = write) |
| cclk_o | output | 1 | Configuration clock |
| data_o | output | 8 | Configuration data bus |
| stat_valid_o | output | 1 | One-cycle strobe for `stat_o` |
| stat_o | output | 72 | Status record |

## Verification
The bench builds the block with `HALF=2`, `RST_CYC=20` and `POLL_MAX=30`. With these values the reset hold and the init-poll timeout both expire within a few dozen cycles, so the timeout path that yields code 100 is exercised. The full closing run of 68 pulses also fits in a short window. The packet-length threshold and pulse counts keep their default values, so the 64-byte boundary and the 64+4 closing pulses are checked exactly as built.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

  localparam int REC_BYTES = 9;
  localparam int REC_W     = 8 * REC_BYTES;
  localparam int CNT_W     = 32;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RST,
    ST_POLL,
    ST_LOAD,
    ST_PUT,
    ST_STRB,
    ST_FIN0,
    ST_FIN1,
    ST_FIN2,
    ST_FIN3,
    ST_REL,
    ST_DONE,
    ST_QREL,
    ST_QSMP
  } cfgm_st_e;

  // Builds the status record; byte k occupies bits 8k+7..8k.
  function automatic logic [REC_W-1:0] pack_rec(
    input logic             unconf,
    input logic [7:0]       sum,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       code,
    input logic [7:0]       ext
  );
    logic [REC_W-1:0] r;
    r          = '0;
    r[7:0]     = {7'd0, unconf};
    r[15:8]    = sum;
    r[47:16]   = cnt;
    r[55:48]   = code;
    r[63:56]   = ext;
    r[71:64]   = 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/cfgm_timer.sv
module cfgm_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgm_strobe.sv
module cfgm_strobe #(
  parameter int HALF = 4,
  parameter int PW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill_i,
  input  logic          start_i,
  input  logic [PW-1:0] n_i,
  output logic          cclk_o,
  output logic          busy_o
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

  logic          cclk_q, cclk_d;
  logic          busy_q, busy_d;
  logic [HW-1:0] half_q, half_d;
  logic [PW-1:0] left_q, left_d;

  always_comb begin
    cclk_d = cclk_q;
    busy_d = busy_q;
    half_d = half_q;
    left_d = left_q;
    if (kill_i) begin
      cclk_d = 1'b0;
      busy_d = 1'b0;
      half_d = '0;
      left_d = '0;
    end else if (!busy_q) begin
      if (start_i && (n_i != '0)) begin
        busy_d = 1'b1;
        cclk_d = 1'b1;
        half_d = HLAST;
        left_d = n_i;
      end
    end else if (half_q != '0) begin
      half_d = half_q - 1'b1;
    end else if (cclk_q) begin
      cclk_d = 1'b0;
      half_d = HLAST;
    end else if (left_q == PW'(1)) begin
      busy_d = 1'b0;
      left_d = '0;
    end else begin
      left_d = left_q - 1'b1;
      cclk_d = 1'b1;
      half_d = HLAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      busy_q <= 1'b0;
      half_q <= '0;
      left_q <= '0;
    end else begin
      cclk_q <= cclk_d;
      busy_q <= busy_d;
      half_q <= half_d;
      left_q <= left_d;
    end
  end

  assign cclk_o = cclk_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/cfgm_accum.sv
module cfgm_accum #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [7:0]    byte_i,
  output logic [7:0]    sum_o,
  output logic [CW-1:0] cnt_o
);

  logic [7:0]    sum_q, sum_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sum_d = '0;
      cnt_d = '0;
    end else if (add_i) begin
      sum_d = sum_q + byte_i;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/cfgm_master.sv
module cfgm_master
  import cfgm_pkg::*;
#(
  parameter int HALF        = 4,
  parameter int RST_CYC     = 500000,
  parameter int POLL_MAX    = 65535,
  parameter int PKT_FULL    = 64,
  parameter int FIN_PULSES  = 64,
  parameter int TAIL_PULSES = 4,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_cmd_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              stat_req_i,
  input  logic [7:0]        ext_res_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              prog_o,
  output logic              prog_oe_o,
  input  logic              done_i,
  input  logic              init_i,
  output logic              bus_oe_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              cs_o,
  output logic              rdwr_o,
  output logic              cclk_o,
  output logic [7:0]        data_o,
  output logic              stat_valid_o,
  output logic [REC_W-1:0]  stat_o
);

  localparam int TMAX  = (RST_CYC > POLL_MAX) ? RST_CYC : POLL_MAX;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PMAX  = (FIN_PULSES > TAIL_PULSES) ? FIN_PULSES : TAIL_PULSES;
  localparam int PW    = $clog2(PMAX + 1);
  localparam int KW    = $clog2(PKT_FULL + 1);
  localparam logic [KW-1:0] PKT_SHORT_LIM = KW'(PKT_FULL - 1);
  localparam logic [KW-1:0] PKT_SAT       = KW'(PKT_FULL);

  cfgm_st_e          st_q, st_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [7:0]        data_q, data_d;
  logic              short_q, short_d;
  logic [KW-1:0]     pkt_q, pkt_d;
  logic [7:0]        code_q, code_d;
  logic              sv_q, sv_d;
  logic [REC_W-1:0]  rec_q, rec_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          strb_kill, strb_start, strb_cclk, strb_busy;
  logic [PW-1:0] strb_n;
  logic          acc_clr, acc_add;
  logic [7:0]    acc_sum;
  logic [CNT_W-1:0] acc_cnt;
  logic          take;

  cfgm_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  cfgm_strobe #(.HALF(HALF), .PW(PW)) u_strb (
    .clk(clk), .rst_n(rst_n), .kill_i(strb_kill), .start_i(strb_start), .n_i(strb_n),
    .cclk_o(strb_cclk), .busy_o(strb_busy)
  );

  cfgm_accum #(.CW(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .add_i(acc_add), .byte_i(s_data_i),
    .sum_o(acc_sum), .cnt_o(acc_cnt)
  );

  assign s_ready_o = (st_q == ST_LOAD) && !stat_req_i && !reset_cmd_i;
  assign take      = s_ready_o && s_valid_i;

  // Next-state and datapath control
  always_comb begin
    st_d       = st_q;
    mode_d     = mode_q;
    data_d     = data_q;
    short_d    = short_q;
    pkt_d      = pkt_q;
    code_d     = code_q;
    sv_d       = 1'b0;
    rec_d      = rec_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    strb_kill  = 1'b0;
    strb_start = 1'b0;
    strb_n     = '0;
    acc_clr    = 1'b0;
    acc_add    = 1'b0;
    if (reset_cmd_i) begin
      st_d      = ST_RST;
      mode_d    = mode_i;
      tmr_load  = 1'b1;
      tmr_val   = TW'(RST_CYC);
      strb_kill = 1'b1;
      acc_clr   = 1'b1;
      pkt_d     = '0;
      short_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_OFF, ST_DONE: begin
          if (stat_req_i) st_d = ST_QREL;
        end
        ST_RST: begin
          if (tmr_zero) begin
            st_d     = ST_POLL;
            tmr_load = 1'b1;
            tmr_val  = TW'(POLL_MAX);
          end
        end
        ST_POLL: begin
          if (init_i || tmr_zero) begin
            code_d = init_i ? 8'd200 : 8'd100;
            st_d   = ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (stat_req_i) begin
            st_d = ST_QREL;
          end else if (take) begin
            acc_add = 1'b1;
            data_d  = s_data_i;
            short_d = s_last_i && (pkt_q < PKT_SHORT_LIM);
            if (s_last_i)           pkt_d = '0;
            else if (pkt_q != PKT_SAT) pkt_d = pkt_q + 1'b1;
            st_d = ST_PUT;
          end
        end
        ST_PUT: begin
          strb_start = 1'b1;
          strb_n     = PW'(1);
          st_d       = ST_STRB;
        end
        ST_STRB: begin
          if (!strb_busy) st_d = short_q ? ST_FIN0 : ST_LOAD;
        end
        ST_FIN0: begin
          code_d     = code_q + (init_i ? 8'd20 : 8'd10);
          strb_start = 1'b1;
          strb_n     = PW'(FIN_PULSES);
          st_d       = ST_FIN1;
        end
        ST_FIN1: begin
          if (!strb_busy) st_d = ST_FIN2;
        end
        ST_FIN2: begin
          strb_start = 1'b1;
          strb_n     = PW'(TAIL_PULSES);
          st_d       = ST_FIN3;
        end
        ST_FIN3: begin
          if (!strb_busy) st_d = ST_REL;
        end
        ST_REL: begin
          code_d = code_q + (init_i ? 8'd2 : 8'd1);
          st_d   = ST_DONE;
        end
        ST_QREL: begin
          st_d = ST_QSMP;
        end
        ST_QSMP: begin
          sv_d  = 1'b1;
          rec_d = pack_rec(!done_i, acc_sum, acc_cnt, code_q, ext_res_i);
          if (done_i) begin
            st_d = ST_DONE;
          end else begin
            st_d     = ST_RST;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC);
            acc_clr  = 1'b1;
            pkt_d    = '0;
            short_d  = 1'b0;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      mode_q  <= '0;
      data_q  <= '0;
      short_q <= 1'b0;
      pkt_q   <= '0;
      code_q  <= '0;
      sv_q    <= 1'b0;
      rec_q   <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      data_q  <= data_d;
      short_q <= short_d;
      pkt_q   <= pkt_d;
      code_q  <= code_d;
      sv_q    <= sv_d;
      rec_q   <= rec_d;
    end
  end

  // Pin decode from state
  always_comb begin
    bus_oe_o = 1'b0;
    unique case (st_q)
      ST_RST, ST_POLL, ST_LOAD, ST_PUT, ST_STRB,
      ST_FIN0, ST_FIN1, ST_FIN2, ST_FIN3: bus_oe_o = 1'b1;
      default: bus_oe_o = 1'b0;
    endcase
  end

  assign prog_oe_o    = bus_oe_o || (st_q == ST_DONE);
  assign prog_o       = (st_q != ST_RST);
  assign cs_o         = (st_q == ST_RST) || (st_q == ST_FIN2) || (st_q == ST_FIN3);
  assign rdwr_o       = 1'b0;
  assign cclk_o       = (st_q == ST_RST) || strb_cclk;
  assign mode_o       = mode_q;
  assign data_o       = data_q;
  assign stat_valid_o = sv_q;
  assign stat_o       = rec_q;

endmodule

// File: rtl/cfgm_master_chk.sv
module cfgm_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_cmd_i,
  input logic        s_ready_o,
  input logic        prog_o,
  input logic        prog_oe_o,
  input logic        bus_oe_o,
  input logic        cs_o,
  input logic        rdwr_o,
  input logic        cclk_o,
  input logic [7:0]  data_o,
  input logic        stat_valid_o,
  input logic [71:0] stat_o
);

  // R1
  rst_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_oe_o && !prog_o) |-> (cs_o && cclk_o && !rdwr_o && bus_oe_o && !s_ready_o));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk_o) && prog_o && bus_oe_o) |-> $stable(data_o));

  // R4
  ready_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> !s_ready_o);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (!s_ready_o && !cclk_o));

  // R9
  query_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_valid_o) |-> $past(!prog_oe_o));

  // R10
  rec_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> (stat_o[71:64] == 8'd1 && stat_o[7:1] == 7'd0));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd_i |=> (prog_oe_o && !prog_o && !s_ready_o));

endmodule

bind cfgm_master cfgm_master_chk u_cfgm_master_chk (
  .clk(clk), .rst_n(rst_n), .reset_cmd_i(reset_cmd_i), .s_ready_o(s_ready_o),
  .prog_o(prog_o), .prog_oe_o(prog_oe_o), .bus_oe_o(bus_oe_o), .cs_o(cs_o),
  .rdwr_o(rdwr_o), .cclk_o(cclk_o), .data_o(data_o), .stat_valid_o(stat_valid_o),
  .stat_o(stat_o)
);

// File: tb/cfgm_master_bench.sv
module cfgm_master_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reset_cmd, stat_req, s_valid, s_last, s_ready;
  logic [1:0]  mode_in, mode_out;
  logic [7:0]  ext_res, s_data, data_out;
  logic        prog, prog_oe, done_line, init_line, bus_oe, cs, rdwr, cclk, stat_valid;
  logic [71:0] stat;

  int total = 0;
  int bad   = 0;
  int fin_low = 0;
  int tail    = 0;
  int cyc     = 0;
  logic [7:0]  exp_sum;
  int          exp_cnt;
  logic [7:0]  exp_q[$];
  logic        prev_cclk = 1'b0;
  logic [71:0] rec;

  always #10 clk = ~clk;

  cfgm_master #(.HALF(2), .RST_CYC(20), .POLL_MAX(30)) u_cfgm_master (
    .clk(clk), .rst_n(rst_n), .reset_cmd_i(reset_cmd), .mode_i(mode_in),
    .stat_req_i(stat_req), .ext_res_i(ext_res), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_last_i(s_last), .s_ready_o(s_ready), .prog_o(prog), .prog_oe_o(prog_oe),
    .done_i(done_line), .init_i(init_line), .bus_oe_o(bus_oe), .mode_o(mode_out),
    .cs_o(cs), .rdwr_o(rdwr), .cclk_o(cclk), .data_o(data_out),
    .stat_valid_o(stat_valid), .stat_o(stat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  // monitor: target model counting clock rises
  always @(negedge clk) begin
    if (cclk && !prev_cclk && prog && prog_oe) begin
      if (!cs) begin
        if (exp_q.size() != 0) begin
          chk("R4 byte", {24'd0, data_out}, {24'd0, exp_q.pop_front()});
        end else begin
          fin_low++;
        end
      end else begin
        tail++;
      end
    end
    prev_cclk <= cclk;
  end

  task automatic pulse_reset(input logic [1:0] m);
    mode_in   = m;
    reset_cmd = 1'b1;
    @(negedge clk);
    reset_cmd = 1'b0;
    exp_q.delete();
    exp_sum = 8'd0;
    exp_cnt = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500; i++) begin
      if (s_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic send(input int n, input logic [7:0] base, input logic with_last);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = base + 8'(i * 7);
      s_valid = 1'b1;
      s_data  = b;
      s_last  = with_last && (i == n - 1);
      wait_ready();
      exp_q.push_back(b);
      exp_sum = exp_sum + b;
      exp_cnt++;
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
    end
  endtask

  task automatic query(output logic [71:0] r);
    r = '0;
    stat_req = 1'b1;
    @(negedge clk);
    stat_req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (stat_valid) begin
        r = stat;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; reset_cmd = 1'b0; stat_req = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    mode_in = 2'b00; ext_res = 8'h5A; s_data = 8'h00; done_line = 1'b0; init_line = 1'b0;
    exp_sum = 8'd0; exp_cnt = 0;
    repeat (4) @(negedge clk);
    // R12 released state
    chk("R12 bus_oe", {31'd0, bus_oe}, 32'd0);
    chk("R12 prog_oe", {31'd0, prog_oe}, 32'd0);
    chk("R12 ready", {31'd0, s_ready}, 32'd0);
    chk("R12 stat_valid", {31'd0, stat_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Run 1: clean load, 64-byte packet then a 5-byte short packet
    init_line = 1'b1;
    pulse_reset(2'b01);
    chk("R1 prog low", {31'd0, prog}, 32'd0);
    chk("R1 cs/cclk/rdwr", {29'd0, cs, cclk, rdwr}, 32'b110);
    chk("R1 mode", {30'd0, mode_out}, 32'd1);
    chk("R1 ready low", {31'd0, s_ready}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R1 still held", {31'd0, prog}, 32'd0);
    wait_ready();
    chk("R2 prog/cs/cclk", {29'd0, prog, cs, cclk}, 32'b100);
    fin_low = 0; tail = 0;
    send(64, 8'h10, 1'b1);
    repeat (12) @(negedge clk);
    chk("R6 full packet keeps loading", {31'd0, s_ready}, 32'd1);
    chk("R6 no closing pulses", fin_low, 0);
    send(5, 8'hE0, 1'b1);
    repeat (400) @(negedge clk);
    chk("R4 all bytes clocked", exp_q.size(), 0);
    chk("R7 pulses with cs low", fin_low, 64);
    chk("R7 pulses with cs high", tail, 4);
    chk("R8 bus released", {31'd0, bus_oe}, 32'd0);
    chk("R8 prog driven high", {30'd0, prog_oe, prog}, 32'b11);
    done_line = 1'b1;
    query(rec);
    chk("R9 configured", {24'd0, rec[7:0]}, 32'd0);
    chk("R5 checksum", {24'd0, rec[15:8]}, {24'd0, exp_sum});
    chk("R5 count", rec[47:16], exp_cnt);
    chk("R8 code 222", {24'd0, rec[55:48]}, 32'd222);
    chk("R10 ext byte", {24'd0, rec[63:56]}, 32'h5A);
    chk("R10 last byte", {24'd0, rec[71:64]}, 32'd1);
    @(negedge clk);
    chk("R9 prog driven high", {30'd0, prog_oe, prog}, 32'b11);

    // Run 2: init never rises, query sees unconfigured
    init_line = 1'b0;
    pulse_reset(2'b11);
    chk("R1 mode 3", {30'd0, mode_out}, 32'd3);
    wait_ready();
    done_line = 1'b0;
    query(rec);
    chk("R2 code 100", {24'd0, rec[55:48]}, 32'd100);
    chk("R3 checksum cleared", {24'd0, rec[15:8]}, 32'd0);
    chk("R3 count cleared", rec[47:16], 32'd0);
    chk("R9 unconfigured", {24'd0, rec[7:0]}, 32'd1);
    chk("R9 reset restarted", {30'd0, prog_oe, prog}, 32'b10);

    // Run 3: abort mid-load, then short load with init low at the close
    init_line = 1'b1;
    wait_ready();
    send(3, 8'h33, 1'b0);
    pulse_reset(2'b01);
    chk("R11 abort to reset", {30'd0, prog, s_ready}, 32'b00);
    wait_ready();
    fin_low = 0; tail = 0;
    init_line = 1'b0;
    send(3, 8'h81, 1'b1);
    repeat (400) @(negedge clk);
    chk("R7 low pulses again", fin_low, 64);
    done_line = 1'b1;
    query(rec);
    chk("R7 code 211", {24'd0, rec[55:48]}, 32'd211);
    chk("R11 count after abort", rec[47:16], 32'd3);
    chk("R5 checksum run 3", {24'd0, rec[15:8]}, {24'd0, exp_sum});
    finish_run();
  end

endmodule